// File: doc/BRIEF.md
# Content-Adaptive Texture Filter Unit

This unit filters the texels of one fragment and chooses, per primitive, between two filter modes. In bilinear mode it blends four texels taken from one mip level. In trilinear mode it blends four texels from each of two adjacent mip levels and then blends the two level results by the level fraction. An upstream address stage supplies the texels, the fractional coordinates and the level fraction. It also supplies the per-primitive control inputs: a texture spatial-frequency class and an object-speed value. The unit returns the filtered RGBA value together with the mode that produced it.

The mode rule is perceptual. Detailed textures on slow objects get trilinear filtering. Low-detail or fast-moving content gets bilinear filtering. The unit drives a mode flag and a one-cycle request strobe for an external voltage and clock controller, which can run bilinear work at half the clock and a lower supply. The new voltage and clock take a long time to settle, so a hold-off counter blocks any further mode change until the programmed switch delay has passed.

The unit has two bilinear pipelines. In trilinear mode they work on the two mip levels of the same fragment. In bilinear mode they take alternate fragments. In both modes one fragment per cycle enters and leaves. Input and output use valid/ready handshakes, and fragments are delivered in order.

Top module: `adaptive_tex_filter`

## Requirements
- R1: In bilinear mode each 8-bit channel c equals (t0*(256-u)*(256-v) + t1*u*(256-v) + t2*(256-u)*v + t3*u*v + 32768) >> 16. Here tj is channel c of texel j of `lvl0_texels_i`. Texel j sits at bits [32j+31:32j] and channel c at bits [8c+7:8c] of the texel. Texel 1 is the +u neighbour of texel 0, and texels 2 and 3 are the +v row.
- R2: In trilinear mode each channel equals (a*(256-l) + b*l + 128) >> 8. Here a and b are the R1 results for `lvl0_texels_i` and `lvl1_texels_i`, and l is `lod_frac_i`.
- R3: For a primitive, the wanted mode is trilinear exactly when `freq_class_i` >= FREQ_MIN and `speed_i` <= SPEED_MAX. Otherwise the wanted mode is bilinear.
- R4: The mode is evaluated only on an accepted fragment with `prim_first_i` = 1. That fragment and all later fragments use the resulting mode until the next such fragment. The control inputs are ignored on other fragments.
- R5: After a mode switch, no further switch takes place within SWITCH_DLY following cycles. A primitive that starts inside that window keeps the current mode.
- R6: `switch_req_o` is high for exactly one cycle, in the first cycle in which `mode_tri_o` shows the new mode. `mode_tri_o` (1 = trilinear) changes at no other time.
- R7: `out_tri_o` gives, for each output fragment, the mode that was used to filter it.
- R8: Fragments leave in the order they were accepted. While `out_valid_o` is high and `out_ready_i` is low, the output holds its value. The latency is two cycles, and one fragment per cycle is sustained in both modes.
- R9: After reset: `out_valid_o` = 0, `mode_tri_o` = 1, `switch_req_o` = 0, and the hold-off counter is clear, so the first wanted switch happens at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Fragment input valid |
| in_ready_o | output | 1 | Fragment input ready |
| prim_first_i | input | 1 | Fragment is the first of a primitive |
| freq_class_i | input | FREQ_W | Texture spatial-frequency class |
| speed_i | input | SPEED_W | Object speed |
| lvl0_texels_i | input | 128 | Four RGBA texels of the finer level |
| lvl1_texels_i | input | 128 | Four RGBA texels of the coarser level |
| u_frac_i | input | 8 | Horizontal weight, 1/256 units |
| v_frac_i | input | 8 | Vertical weight, 1/256 units |
| lod_frac_i | input | 8 | Level blend weight, 1/256 units |
| out_valid_o | output | 1 | Filtered fragment valid |
| out_ready_i | input | 1 | Downstream ready |
| out_rgba_o | output | 32 | Filtered RGBA |
| out_tri_o | output | 1 | Fragment was filtered trilinearly |
| mode_tri_o | output | 1 | Current mode for the scaling controller |
| switch_req_o | output | 1 | One-cycle mode change request strobe |

## Verification
The bench targets the weight extremes 0 and 255, where a design that computes the complement as 255-f instead of 256-f, or that leaves out the rounding constant, gives results one or more codes off. It places primitive starts inside the hold-off window, where a design without the counter would switch early and tag fragments with the wrong mode. It also sends control values on fragments that do not start a primitive, which a design that evaluates every fragment would act on by mistake. Random backpressure exposes any loss, duplication or reordering of fragments across the two alternating pipelines.

// File: rtl/tex_filt_pkg.sv
`timescale 1ns/1ps
package tex_filt_pkg;
  localparam int CH_W    = 8;
  localparam int N_CH    = 4;
  localparam int TEXEL_W = CH_W * N_CH;
  localparam int N_TAP   = 4;
  localparam int QUAD_W  = TEXEL_W * N_TAP;
  localparam int FRAC_W  = 8;

  typedef logic [TEXEL_W-1:0] rgba_t;
  typedef logic [QUAD_W-1:0]  quad_t;

  // one-dimensional blend, rounded to nearest
  function automatic logic [CH_W-1:0] lerp_ch(logic [CH_W-1:0] a, logic [CH_W-1:0] b,
                                              logic [FRAC_W-1:0] f);
    logic [17:0] acc;
    acc = 18'(a) * 18'(9'd256 - 9'(f)) + 18'(b) * 18'(f) + 18'd128;
    return acc[15:8];
  endfunction
endpackage

// File: rtl/tex_filt_bilerp.sv
`timescale 1ns/1ps
module tex_filt_bilerp
  import tex_filt_pkg::*;
(
  input  logic [QUAD_W-1:0]  quad_i,
  input  logic [FRAC_W-1:0]  u_i,
  input  logic [FRAC_W-1:0]  v_i,
  output logic [TEXEL_W-1:0] rgba_o
);
  logic [8:0]  iu, iv;
  logic [16:0] w [N_TAP];

  assign iu = 9'd256 - {1'b0, u_i};
  assign iv = 9'd256 - {1'b0, v_i};

  always_comb begin
    w[0] = 17'(iu) * 17'(iv);
    w[1] = 17'(u_i) * 17'(iv);
    w[2] = 17'(iu) * 17'(v_i);
    w[3] = 17'(u_i) * 17'(v_i);
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [24:0] acc;
    always_comb begin
      acc = 25'd32768;
      for (int j = 0; j < N_TAP; j++)
        acc = acc + 25'(quad_i[TEXEL_W*j + CH_W*c +: CH_W]) * 25'(w[j]);
    end
    assign rgba_o[CH_W*c +: CH_W] = acc[23:16];
  end
endmodule

// File: rtl/tex_filt_mode_ctrl.sv
`timescale 1ns/1ps
module tex_filt_mode_ctrl #(
  parameter int FREQ_W     = 2,
  parameter int SPEED_W    = 8,
  parameter int FREQ_MIN   = 2,
  parameter int SPEED_MAX  = 64,
  parameter int SWITCH_DLY = 10000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic               first_i,
  input  logic [FREQ_W-1:0]  freq_i,
  input  logic [SPEED_W-1:0] speed_i,
  output logic               frag_tri_o,
  output logic               mode_tri_o,
  output logic               switch_req_o
);
  localparam int HW = $clog2(SWITCH_DLY + 1);

  logic [HW-1:0] hold_q;
  logic          want_tri, do_switch;

  assign want_tri   = (32'(freq_i) >= 32'(FREQ_MIN)) && (32'(speed_i) <= 32'(SPEED_MAX));
  assign do_switch  = first_i && (hold_q == '0) && (want_tri != mode_tri_o);
  assign frag_tri_o = do_switch ? want_tri : mode_tri_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_tri_o   <= 1'b1;
      switch_req_o <= 1'b0;
      hold_q       <= '0;
    end else begin
      switch_req_o <= accept_i && do_switch;
      if (accept_i) mode_tri_o <= frag_tri_o;
      if (accept_i && do_switch) hold_q <= HW'(SWITCH_DLY);
      else if (hold_q != '0)     hold_q <= hold_q - 1'b1;
    end
  end
endmodule

// File: rtl/adaptive_tex_filter.sv
`timescale 1ns/1ps
module adaptive_tex_filter
  import tex_filt_pkg::*;
#(
  parameter int FREQ_W     = 2,
  parameter int SPEED_W    = 8,
  parameter int FREQ_MIN   = 2,
  parameter int SPEED_MAX  = 64,
  parameter int SWITCH_DLY = 10000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic               prim_first_i,
  input  logic [FREQ_W-1:0]  freq_class_i,
  input  logic [SPEED_W-1:0] speed_i,
  input  logic [127:0]       lvl0_texels_i,
  input  logic [127:0]       lvl1_texels_i,
  input  logic [7:0]         u_frac_i,
  input  logic [7:0]         v_frac_i,
  input  logic [7:0]         lod_frac_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [31:0]        out_rgba_o,
  output logic               out_tri_o,
  output logic               mode_tri_o,
  output logic               switch_req_o
);
  localparam int N_PIPE = 2;

  logic accept, s1_adv, s2_adv, frag_tri;
  logic sel_q;

  assign s2_adv     = !out_valid_o || out_ready_i;
  assign in_ready_o = s1_adv;
  assign accept     = in_valid_i && in_ready_o;

  tex_filt_mode_ctrl #(
    .FREQ_W(FREQ_W), .SPEED_W(SPEED_W), .FREQ_MIN(FREQ_MIN),
    .SPEED_MAX(SPEED_MAX), .SWITCH_DLY(SWITCH_DLY)
  ) u_mode (
    .clk_i, .rst_ni,
    .accept_i    (accept),
    .first_i     (prim_first_i),
    .freq_i      (freq_class_i),
    .speed_i     (speed_i),
    .frag_tri_o  (frag_tri),
    .mode_tri_o  (mode_tri_o),
    .switch_req_o(switch_req_o)
  );

  // trilinear: pipe p takes level p; bilinear: pipe sel_q takes level 0, other idles at zero
  rgba_t bil_res [N_PIPE];
  for (genvar p = 0; p < N_PIPE; p++) begin : g_pipe
    logic        use_p;
    quad_t       quad_p;
    logic [7:0]  u_p, v_p;
    assign use_p  = frag_tri || (sel_q == 1'(p));
    assign quad_p = !use_p ? '0 : (frag_tri && p == 1) ? lvl1_texels_i : lvl0_texels_i;
    assign u_p    = use_p ? u_frac_i : '0;
    assign v_p    = use_p ? v_frac_i : '0;
    tex_filt_bilerp u_bil (.quad_i(quad_p), .u_i(u_p), .v_i(v_p), .rgba_o(bil_res[p]));
  end

  // stage 1
  logic       s1_valid_q, s1_tri_q, s1_sel_q;
  rgba_t      s1_b0_q, s1_b1_q;
  logic [7:0] s1_lod_q;

  assign s1_adv = !s1_valid_q || s2_adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_tri_q   <= 1'b0;
      s1_sel_q   <= 1'b0;
      s1_b0_q    <= '0;
      s1_b1_q    <= '0;
      s1_lod_q   <= '0;
      sel_q      <= 1'b0;
    end else if (s1_adv) begin
      s1_valid_q <= in_valid_i;
      if (accept) begin
        s1_tri_q <= frag_tri;
        s1_sel_q <= sel_q;
        s1_b0_q  <= bil_res[0];
        s1_b1_q  <= bil_res[1];
        s1_lod_q <= lod_frac_i;
        if (!frag_tri) sel_q <= ~sel_q;
      end
    end
  end

  // stage 2: level blend or pipe pick
  rgba_t blend;
  for (genvar c = 0; c < N_CH; c++) begin : g_blend
    assign blend[CH_W*c +: CH_W] = lerp_ch(s1_b0_q[CH_W*c +: CH_W], s1_b1_q[CH_W*c +: CH_W], s1_lod_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_rgba_o  <= '0;
      out_tri_o   <= 1'b0;
    end else if (s2_adv) begin
      out_valid_o <= s1_valid_q;
      if (s1_valid_q) begin
        out_rgba_o <= s1_tri_q ? blend : (s1_sel_q ? s1_b1_q : s1_b0_q);
        out_tri_o  <= s1_tri_q;
      end
    end
  end
endmodule

// File: rtl/adaptive_tex_filter_chk.sv
`timescale 1ns/1ps
module adaptive_tex_filter_chk #(
  parameter int SWITCH_DLY = 10000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        prim_first_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_rgba_o,
  input logic        out_tri_o,
  input logic        mode_tri_o,
  input logic        switch_req_o
);
  localparam int GW = $clog2(SWITCH_DLY + 1);
  logic [GW-1:0] gap_q;

  // cycles since the last request strobe, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           gap_q <= GW'(SWITCH_DLY);
    else if (switch_req_o) gap_q <= '0;
    else if (gap_q != GW'(SWITCH_DLY)) gap_q <= gap_q + 1'b1;
  end

  p_req_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o |=> !switch_req_o);

  p_mode_moves_with_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_tri_o != $past(mode_tri_o)) |-> switch_req_o);

  p_switch_on_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o |-> $past(in_valid_i && in_ready_o && prim_first_i));

  p_holdoff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o |-> (gap_q == GW'(SWITCH_DLY)));

  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_rgba_o) && $stable(out_tri_o)));
endmodule

bind adaptive_tex_filter adaptive_tex_filter_chk #(.SWITCH_DLY(SWITCH_DLY)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .prim_first_i(prim_first_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_rgba_o(out_rgba_o), .out_tri_o(out_tri_o), .mode_tri_o(mode_tri_o),
  .switch_req_o(switch_req_o)
);

// File: tb/adaptive_tex_filter_bench.sv
`timescale 1ns/1ps
module adaptive_tex_filter_bench;
  localparam int DLY       = 40;
  localparam int FREQ_MIN  = 2;
  localparam int SPEED_MAX = 64;
  localparam int NDIR      = 6;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready, first = 1'b0;
  logic [1:0]   freq = '0;
  logic [7:0]   speed = '0;
  logic [127:0] t0 = '0, t1 = '0;
  logic [7:0]   u = '0, v = '0, lod = '0;
  logic         out_valid, out_ready = 1'b0, out_tri, mode_tri, switch_req;
  logic [31:0]  out_rgba;

  always #5 clk = ~clk;

  adaptive_tex_filter #(.FREQ_MIN(FREQ_MIN), .SPEED_MAX(SPEED_MAX), .SWITCH_DLY(DLY)) u_adaptive_tex_filter (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .prim_first_i(first), .freq_class_i(freq), .speed_i(speed),
    .lvl0_texels_i(t0), .lvl1_texels_i(t1), .u_frac_i(u), .v_frac_i(v), .lod_frac_i(lod),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_rgba_o(out_rgba),
    .out_tri_o(out_tri), .mode_tri_o(mode_tri), .switch_req_o(switch_req));

  int checks = 0, errors = 0;
  logic [31:0] q_rgba[$];
  bit          q_tri[$];
  bit          m_mode = 1'b1, m_req = 1'b0, pend = 1'b0;
  int          m_hold = 0, prim_left = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] bil_ref(logic [127:0] q, int fu, int fv);
    logic [31:0] r;
    for (int c = 0; c < 4; c++) begin
      int s;
      s = 32768;
      s += int'(q[0*32+8*c +: 8]) * (256-fu) * (256-fv);
      s += int'(q[1*32+8*c +: 8]) * fu * (256-fv);
      s += int'(q[2*32+8*c +: 8]) * (256-fu) * fv;
      s += int'(q[3*32+8*c +: 8]) * fu * fv;
      r[8*c +: 8] = 8'(s >> 16);
    end
    return r;
  endfunction

  function automatic logic [31:0] tri_ref(logic [31:0] a, logic [31:0] b, int l);
    logic [31:0] r;
    for (int c = 0; c < 4; c++)
      r[8*c +: 8] = 8'((int'(a[8*c +: 8]) * (256-l) + int'(b[8*c +: 8]) * l + 128) >> 8);
    return r;
  endfunction

  function automatic logic [7:0] rnd_frac();
    int k;
    k = int'($urandom % 10);
    if (k == 0) return 8'd0;
    if (k == 1) return 8'd255;
    return 8'($urandom);
  endfunction

  task automatic drive(int cyc);
    if (!pend) begin
      if (cyc < NDIR) begin
        in_valid = 1'b1; first = 1'b1;
        case (cyc)
          0: begin freq = 2'd3; speed = 8'd0;   t0 = {4{32'hFFFF_FFFF}}; u = 8'd255; v = 8'd255; lod = 8'd255; end
          1: begin freq = 2'd0; speed = 8'd0;   t0 = 128'h0102_0304_1122_3344_A0B0_C0D0_FF00_FF00; u = 8'd0; v = 8'd0; lod = 8'd0; end
          2: begin freq = 2'd3; speed = 8'd10;  t0 = 128'h8080_8080_0000_0000_FFFF_FFFF_1234_5678; u = 8'd128; v = 8'd0; lod = 8'd7; end
          3: begin freq = 2'd2; speed = 8'd64;  t0 = 128'hFF00_FF00_00FF_00FF_F0F0_F0F0_0F0F_0F0F; u = 8'd255; v = 8'd1; lod = 8'd128; end
          4: begin freq = 2'd3; speed = 8'd200; t0 = 128'h1; u = 8'd1; v = 8'd255; lod = 8'd1; end
          default: begin freq = 2'd1; speed = 8'd0; t0 = 128'hDEAD_BEEF_CAFE_F00D_0BAD_F00D_5A5A_A5A5; u = 8'd200; v = 8'd100; lod = 8'd50; end
        endcase
        t1 = ~t0;
      end else if ($urandom % 10 < 8) begin
        in_valid = 1'b1;
        if (prim_left == 0) begin
          first = 1'b1; prim_left = 1 + int'($urandom % 6);
          freq = 2'($urandom); speed = 8'($urandom % 128);
        end else begin
          first = 1'b0;
          // control values on non-first fragments must be ignored (R4)
          freq = 2'($urandom); speed = 8'($urandom % 128);
        end
        prim_left--;
        t0 = {$urandom, $urandom, $urandom, $urandom};
        t1 = {$urandom, $urandom, $urandom, $urandom};
        u = rnd_frac(); v = rnd_frac(); lod = rnd_frac();
      end else begin
        in_valid = 1'b0; first = 1'b0;
      end
    end
    out_ready = (cyc < NDIR) ? 1'b1 : (($urandom % 4) != 0);
  endtask

  task automatic step();
    bit acc, oacc, want, sw, ftri;
    logic [31:0] exp_rgba;
    bit exp_tri;
    acc  = in_valid && in_ready;
    oacc = out_valid && out_ready;
    chk(mode_tri == m_mode, "R3/R4/R5 mode_tri_o", 32'(mode_tri), 32'(m_mode));
    chk(switch_req == m_req, "R6 switch_req_o", 32'(switch_req), 32'(m_req));
    if (oacc) begin
      if (q_rgba.size() == 0) begin
        chk(1'b0, "R8 unexpected output", out_rgba, 32'h0);
      end else begin
        exp_rgba = q_rgba.pop_front();
        exp_tri  = q_tri.pop_front();
        chk(out_rgba == exp_rgba, exp_tri ? "R2/R8 trilinear rgba" : "R1/R8 bilinear rgba", out_rgba, exp_rgba);
        chk(out_tri == exp_tri, "R7 out_tri_o", 32'(out_tri), 32'(exp_tri));
      end
    end
    sw = 1'b0;
    if (acc) begin
      want = (int'(freq) >= FREQ_MIN) && (int'(speed) <= SPEED_MAX);
      sw   = first && (m_hold == 0) && (want != m_mode);
      ftri = sw ? want : m_mode;
      q_tri.push_back(ftri);
      q_rgba.push_back(ftri ? tri_ref(bil_ref(t0, int'(u), int'(v)), bil_ref(t1, int'(u), int'(v)), int'(lod))
                            : bil_ref(t0, int'(u), int'(v)));
      m_mode = ftri;
    end
    m_req = sw;
    if (sw) m_hold = DLY;
    else if (m_hold > 0) m_hold--;
    pend = in_valid && !acc;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 out_valid_o in reset", 32'(out_valid), 32'h0);
    chk(mode_tri == 1'b1, "R9 mode_tri_o in reset", 32'(mode_tri), 32'h1);
    chk(switch_req == 1'b0, "R9 switch_req_o in reset", 32'(switch_req), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      drive(cyc);
      #1;
      step();
      // directed: primitive in hold-off window keeps bilinear (R5)
      if (cyc == 3) chk(mode_tri == 1'b0, "R5 held in bilinear", 32'(mode_tri), 32'h0);
      @(negedge clk);
    end
    in_valid = 1'b0; first = 1'b0; out_ready = 1'b1; pend = 1'b0;
    for (int k = 0; k < 10; k++) begin
      #1;
      step();
      @(negedge clk);
    end
    chk(q_rgba.size() == 0, "R8 all fragments delivered", 32'(q_rgba.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule